// File: doc/BRIEF.md
# Memory-Mapped Interval Timer

The block is a down-counting interval timer that sits on a simple word-addressed register bus and runs from the bus clock. Software loads a period as two 16-bit halves, then issues a start command; the counter steps down once per clock and expires after period+1 clocks. At expiry a timeout flag is set and the period is reloaded. In one-shot mode the timer then stops, holding the count at the period value. In continuous mode it keeps going.

A level interrupt is raised while the timeout flag is set and interrupts are enabled. Start and stop are self-clearing command bits in the control register. The live count is never read directly. Software first writes either snapshot offset, which copies the counter into two 16-bit snapshot halves, and then reads those halves. Any write to a period half halts the timer and loads the counter with the new period.

Top module: `ivt_timer`

## Requirements
- R1: After reset every readable register reads 0, the timer is stopped, the interrupt is low and the counter holds all ones, so a snapshot taken right after reset reads 0xFFFF in both halves.
- R2: The word offset is the byte address shifted right by two, and the low two address bits are ignored. Offset 0 is status, 1 control, 2 period low, 3 period high, 4 snapshot low and 5 snapshot high. Other offsets read 0, and writes to them change nothing.
- R3: Status bit 0 is the timeout flag and bit 1 is the running flag. A write to status clears the timeout flag only, whatever the data, and leaves the running flag unchanged.
- R4: Control bit 0 is interrupt enable and bit 1 is continuous mode. Both are stored. Bit 2 (start) and bit 3 (stop) are commands that are not stored, so a control read returns only bits 1:0.
- R5: Start sets the running flag only when the timer is stopped. Stop clears it only when the timer is running. When one write carries both, the timer ends up stopped. While stopped, the count does not change.
- R6: A write to either period half stores the low 16 bits of the data, stops a running timer, and loads the counter with {period high, period low}.
- R7: From the start write, the timeout flag is set on the (period+1)-th clock edge. Before that edge the count falls by one per clock.
- R8: In one-shot mode (continuous bit 0), expiry clears the running flag and leaves the count at the period value.
- R9: In continuous mode, expiry reloads the period and the timer keeps running, so it times out again every period+1 clocks.
- R10: A write to offset 4 or 5 captures the counter value at that edge into the snapshot halves, bits 15:0 into low and bits 31:16 into high. The write data is not stored.
- R11: The interrupt output is high exactly when both the timeout flag and interrupt enable are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The bench uses the default parameters: a 5-bit byte address, 32-bit data and 16-bit halves. The 5-bit address makes word offsets 6 and 7 reachable as unmapped locations. The 16-bit halves let a nonzero period-high write move the counter into its upper half, where the snapshot split can be seen. Short periods of 3 and 5 let the one-shot expiry, continuous reload, status clear during running, and the stop and period-write halts be checked on the exact edge.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    localparam int N_MAPPED  = 6;

    localparam int OFS_STATUS = 0;
    localparam int OFS_CTRL   = 1;
    localparam int OFS_PLO    = 2;
    localparam int OFS_PHI    = 3;
    localparam int OFS_SLO    = 4;
    localparam int OFS_SHI    = 5;

    localparam int BIT_TO    = 0;
    localparam int BIT_RUN   = 1;
    localparam int BIT_IE    = 0;
    localparam int BIT_CONT  = 1;
    localparam int BIT_START = 2;
    localparam int BIT_STOP  = 3;

    typedef struct packed {
        logic status_wr;
        logic ctrl_wr;
        logic plo_wr;
        logic phi_wr;
        logic snap_wr;
    } wr_req_t;

    typedef struct packed {
        logic ie;
        logic cont;
    } ctrl_t;

    function automatic wr_req_t decode_wr(input logic we, input int unsigned ofs);
        wr_req_t r;
        r.status_wr = we && (ofs == OFS_STATUS);
        r.ctrl_wr   = we && (ofs == OFS_CTRL);
        r.plo_wr    = we && (ofs == OFS_PLO);
        r.phi_wr    = we && (ofs == OFS_PHI);
        r.snap_wr   = we && ((ofs == OFS_SLO) || (ofs == OFS_SHI));
        return r;
    endfunction

endpackage

// File: rtl/ivt_decode.sv
module ivt_decode
    import ivt_pkg::*;
#(
    parameter int ADDR_W = 5,
    localparam int WOFS_W = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output logic [WOFS_W-1:0] wofs,
    output wr_req_t           wreq
);
    assign wofs = addr[ADDR_W-1:2];
    assign wreq = decode_wr(we, 32'(wofs));
endmodule

// File: rtl/ivt_ctrl_regs.sv
module ivt_ctrl_regs
    import ivt_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wreq,
    input  logic [HALF_W-1:0] wdata,
    input  logic              expire,
    output ctrl_t             ctrl_q,
    output logic              run_q,
    output logic              to_q,
    output logic [HALF_W-1:0] plo_q,
    output logic [HALF_W-1:0] phi_q,
    output logic [HALF_W-1:0] plo_d,
    output logic [HALF_W-1:0] phi_d,
    output logic              hold
);
    ctrl_t ctrl_d;
    logic  run_d;
    logic  to_d;
    logic  cmd_start;
    logic  cmd_stop;

    assign cmd_start = wdata[BIT_START];
    assign cmd_stop  = wdata[BIT_STOP];

    // counter is frozen on edges where a write halts it
    assign hold = wreq.plo_wr | wreq.phi_wr | (wreq.ctrl_wr & cmd_stop);

    always_comb begin
        plo_d = wreq.plo_wr ? wdata : plo_q;
        phi_d = wreq.phi_wr ? wdata : phi_q;

        ctrl_d = ctrl_q;
        if (wreq.ctrl_wr) begin
            ctrl_d.ie   = wdata[BIT_IE];
            ctrl_d.cont = wdata[BIT_CONT];
        end

        run_d = run_q;
        if (wreq.ctrl_wr) begin
            if (cmd_start && !run_d) run_d = 1'b1;
            if (cmd_stop && run_d)   run_d = 1'b0;
        end
        if (wreq.plo_wr || wreq.phi_wr) run_d = 1'b0;
        if (expire && !ctrl_q.cont)     run_d = 1'b0;

        to_d = to_q;
        if (wreq.status_wr) to_d = 1'b0;
        if (expire)         to_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            run_q  <= 1'b0;
            to_q   <= 1'b0;
            plo_q  <= '0;
            phi_q  <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            run_q  <= run_d;
            to_q   <= to_d;
            plo_q  <= plo_d;
            phi_q  <= phi_d;
        end
    end
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             hold,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire
);
    assign expire = run && !hold && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '1;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (expire) begin
            cnt_q <= reload_val;
        end else if (run && !hold) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/ivt_snapshot.sv
module ivt_snapshot #(
    parameter int HALF_W = 16,
    localparam int CNT_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [CNT_W-1:0]  cnt,
    output logic [HALF_W-1:0] slo_q,
    output logic [HALF_W-1:0] shi_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            slo_q <= '0;
            shi_q <= '0;
        end else if (capture) begin
            slo_q <= cnt[HALF_W-1:0];
            shi_q <= cnt[CNT_W-1:HALF_W];
        end
    end
endmodule

// File: rtl/ivt_rdmux.sv
module ivt_rdmux
    import ivt_pkg::*;
#(
    parameter int WOFS_W = 3,
    parameter int DATA_W = 32,
    parameter int HALF_W = 16
) (
    input  logic [WOFS_W-1:0] wofs,
    input  logic              to,
    input  logic              run,
    input  ctrl_t             ctrl,
    input  logic [HALF_W-1:0] plo,
    input  logic [HALF_W-1:0] phi,
    input  logic [HALF_W-1:0] slo,
    input  logic [HALF_W-1:0] shi,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        case (32'(wofs))
            OFS_STATUS: begin
                rdata[BIT_TO]  = to;
                rdata[BIT_RUN] = run;
            end
            OFS_CTRL: begin
                rdata[BIT_IE]   = ctrl.ie;
                rdata[BIT_CONT] = ctrl.cont;
            end
            OFS_PLO: rdata[HALF_W-1:0] = plo;
            OFS_PHI: rdata[HALF_W-1:0] = phi;
            OFS_SLO: rdata[HALF_W-1:0] = slo;
            OFS_SHI: rdata[HALF_W-1:0] = shi;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
    import ivt_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int WOFS_W = ADDR_W - 2;
    localparam int CNT_W  = 2 * HALF_W;

    logic [WOFS_W-1:0] wofs;
    wr_req_t           wreq;
    ctrl_t             ctrl_q;
    logic              run_q;
    logic              to_q;
    logic [HALF_W-1:0] plo_q, phi_q, plo_d, phi_d;
    logic [HALF_W-1:0] slo_q, shi_q;
    logic              hold;
    logic              expire;
    logic [CNT_W-1:0]  cnt_q;
    logic              unused_bits;

    assign unused_bits = ^{bus_wdata[DATA_W-1:HALF_W], bus_addr[1:0]};

    ivt_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .we   (bus_wr),
        .wofs (wofs),
        .wreq (wreq)
    );

    ivt_ctrl_regs #(.HALF_W(HALF_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wreq   (wreq),
        .wdata  (bus_wdata[HALF_W-1:0]),
        .expire (expire),
        .ctrl_q (ctrl_q),
        .run_q  (run_q),
        .to_q   (to_q),
        .plo_q  (plo_q),
        .phi_q  (phi_q),
        .plo_d  (plo_d),
        .phi_d  (phi_d),
        .hold   (hold)
    );

    ivt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .run        (run_q),
        .hold       (hold),
        .load       (wreq.plo_wr | wreq.phi_wr),
        .load_val   ({phi_d, plo_d}),
        .reload_val ({phi_q, plo_q}),
        .cnt_q      (cnt_q),
        .expire     (expire)
    );

    ivt_snapshot #(.HALF_W(HALF_W)) u_snap (
        .clk     (clk),
        .rst     (rst),
        .capture (wreq.snap_wr),
        .cnt     (cnt_q),
        .slo_q   (slo_q),
        .shi_q   (shi_q)
    );

    ivt_rdmux #(.WOFS_W(WOFS_W), .DATA_W(DATA_W), .HALF_W(HALF_W)) u_rd (
        .wofs  (wofs),
        .to    (to_q),
        .run   (run_q),
        .ctrl  (ctrl_q),
        .plo   (plo_q),
        .phi   (phi_q),
        .slo   (slo_q),
        .shi   (shi_q),
        .rdata (bus_rdata)
    );

    assign irq = to_q & ctrl_q.ie;
endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk
    import ivt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input wr_req_t          wreq,
    input logic [3:0]       cmd,
    input logic             run,
    input logic             to,
    input logic             cont,
    input logic             ie,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] period,
    input logic             expire,
    input logic             irq
);
    AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wreq.status_wr && !expire) |=> !to); // R3

    AST_BOTH_CMDS_STOP: assert property (@(posedge clk) disable iff (rst)
        (wreq.ctrl_wr && cmd[BIT_START] && cmd[BIT_STOP]) |=> !run); // R5

    AST_PERIOD_HALTS: assert property (@(posedge clk) disable iff (rst)
        (wreq.plo_wr || wreq.phi_wr) |=> (!run && cnt == period)); // R6

    AST_EXPIRE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        expire |=> to); // R7

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        (run && cnt != '0 && !wreq.ctrl_wr && !wreq.plo_wr && !wreq.phi_wr)
        |=> (cnt == $past(cnt) - 1'b1)); // R7

    AST_ONESHOT_END: assert property (@(posedge clk) disable iff (rst)
        (expire && !cont) |=> (!run && cnt == $past(period))); // R8

    AST_CONT_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (expire && cont) |=> (run && cnt == $past(period))); // R9

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(expire || wreq.ctrl_wr)); // R11

    AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
        (wreq.ctrl_wr && !cmd[BIT_IE]) |=> !irq); // R11
endmodule

bind ivt_timer ivt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .wreq   (wreq),
    .cmd    (bus_wdata[3:0]),
    .run    (run_q),
    .to     (to_q),
    .cont   (ctrl_q.cont),
    .ie     (ctrl_q.ie),
    .cnt    (cnt_q),
    .period ({phi_q, plo_q}),
    .expire (expire),
    .irq    (irq)
);

// File: tb/ivt_timer_test.sv
module ivt_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;

    localparam int A_STATUS = 0;
    localparam int A_CTRL   = 4;
    localparam int A_PLO    = 8;
    localparam int A_PHI    = 12;
    localparam int A_SLO    = 16;
    localparam int A_SHI    = 20;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        bit          is_irq;
        logic [DATA_W-1:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ivt_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HALF_W(16)) uut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            item_t it;
            wait (sb.size() != 0);
            #1;
            it = sb.pop_front();
            checks++;
            if (it.is_irq) begin
                if (irq !== it.exp[0]) begin
                    fails++;
                    $display("FAIL %s: irq=%0b expected %0b", it.tag, irq, it.exp[0]);
                end
            end else if (bus_rdata !== it.exp) begin
                fails++;
                $display("FAIL %s: rdata=%h expected %h", it.tag, bus_rdata, it.exp);
            end
        end
    end

    // all tasks start and end just after a falling edge
    task automatic wr(input int a, input logic [DATA_W-1:0] d);
        bus_addr  = ADDR_W'(a);
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input int a, input logic [DATA_W-1:0] e, input string tag);
        item_t it;
        bus_addr = ADDR_W'(a);
        it.is_irq = 1'b0;
        it.exp = e;
        it.tag = tag;
        sb.push_back(it);
        #2;
    endtask

    task automatic ck_irq(input logic e, input string tag);
        item_t it;
        it.is_irq = 1'b1;
        it.exp = DATA_W'(e);
        it.tag = tag;
        sb.push_back(it);
        #2;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);

        // reset values, R1
        rd(A_STATUS, 0, "R1 status");
        rd(A_CTRL, 0, "R1 ctrl");
        rd(A_PLO, 0, "R1 plo");
        rd(A_PHI, 0, "R1 phi");
        rd(A_SLO, 0, "R1 slo");
        rd(A_SHI, 0, "R1 shi");
        ck_irq(1'b0, "R1 irq");
        wr(A_SLO, 32'h0);
        rd(A_SLO, 32'hFFFF, "R1 count ones low");
        rd(A_SHI, 32'hFFFF, "R1 count ones high");

        // control storage and commands, R4 R5
        wr(A_CTRL, 32'hFFFF_FF0F);
        rd(A_CTRL, 32'h3, "R4 ctrl readback");
        rd(A_STATUS, 32'h0, "R5 start+stop ends stopped");
        wr(A_CTRL, 32'h0);

        // period storage, R6, address low bits ignored R2
        wr(A_PLO, 32'hABCD_0005);
        rd(A_PLO, 32'h5, "R6 plo low bits");
        wr(A_PHI, 32'h0);
        rd(A_PHI, 32'h0, "R6 phi");
        rd(A_PLO + 1, 32'h5, "R2 byte bits ignored");

        // one-shot, period 5
        wr(A_CTRL, 32'h5);
        rd(A_STATUS, 32'h2, "R5 start sets running");
        idle(5);
        rd(A_STATUS, 32'h2, "R7 not yet expired");
        ck_irq(1'b0, "R11 irq before expiry");
        idle(1);
        rd(A_STATUS, 32'h1, "R8 one-shot expired");
        ck_irq(1'b1, "R11 irq on timeout");
        wr(A_SLO, 32'hDEAD_BEEF);
        rd(A_SLO, 32'h5, "R8 count held at period");
        idle(4);
        rd(A_STATUS, 32'h1, "R8 stays stopped");
        wr(A_CTRL, 32'h0);
        ck_irq(1'b0, "R11 irq masked");
        rd(A_STATUS, 32'h1, "R11 flag kept while masked");
        wr(A_STATUS, 32'h0);
        rd(A_STATUS, 32'h0, "R3 clear timeout");

        // continuous, period 3
        wr(A_PLO, 32'h3);
        wr(A_CTRL, 32'h7);
        idle(4);
        rd(A_STATUS, 32'h3, "R9 expiry keeps running");
        ck_irq(1'b1, "R11 irq continuous");
        wr(A_STATUS, 32'hFFFF_FFFF);
        rd(A_STATUS, 32'h2, "R3 only timeout cleared");
        idle(2);
        rd(A_STATUS, 32'h2, "R9 before second expiry");
        idle(1);
        rd(A_STATUS, 32'h3, "R9 second expiry");

        // stop, count frozen
        wr(A_CTRL, 32'h8);
        rd(A_STATUS, 32'h1, "R5 stop clears running");
        wr(A_SHI, 32'h1234_5678);
        rd(A_SLO, 32'h3, "R10 snapshot of stopped count");
        idle(3);
        wr(A_SLO, 32'h0);
        rd(A_SLO, 32'h3, "R5 count frozen while stopped");
        wr(A_CTRL, 32'h8);
        rd(A_STATUS, 32'h1, "R5 stop when stopped");

        // period write while running halts and loads
        wr(A_STATUS, 32'h0);
        wr(A_CTRL, 32'h4);
        rd(A_STATUS, 32'h2, "R5 restart");
        wr(A_PHI, 32'h0001);
        rd(A_STATUS, 32'h0, "R6 period write halts");
        wr(A_SLO, 32'h0);
        rd(A_SLO, 32'h3, "R6 load low");
        rd(A_SHI, 32'h1, "R6 load high");

        // live snapshots while running, R10 R7
        wr(A_CTRL, 32'h4);
        wr(A_SLO, 32'h0);
        rd(A_SLO, 32'h3, "R10 first snapshot low");
        rd(A_SHI, 32'h1, "R10 first snapshot high");
        wr(A_SHI, 32'h0);
        rd(A_SLO, 32'h2, "R7 one step down");
        rd(A_SHI, 32'h1, "R10 second snapshot high");

        // unmapped offsets, R2
        wr(A_CTRL, 32'hB);
        wr(A_STATUS, 32'h0);
        rd(A_CTRL, 32'h3, "R2 ctrl before");
        wr(24, 32'hFFFF_FFFF);
        wr(28, 32'hFFFF_FFFF);
        rd(24, 32'h0, "R2 offset 6 reads zero");
        rd(28, 32'h0, "R2 offset 7 reads zero");
        rd(A_CTRL, 32'h3, "R2 ctrl untouched");
        rd(A_PLO, 32'h3, "R2 plo untouched");
        rd(A_PHI, 32'h1, "R2 phi untouched");
        rd(A_STATUS, 32'h0, "R2 status untouched");

        wait (sb.size() == 0);
        #2;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule